// File: doc/BRIEF.md
# Descriptor-Chaining DMA Channel

This block is a single DMA channel that copies 32-bit words between a host-side memory port and a local-side memory port. Software sets it up through a small register file and then writes a start strobe. In direct mode the channel makes one transfer, using the addresses, byte count and link word held in its own registers. In chained mode it reads a four-word descriptor from memory, runs the transfer that descriptor describes, and then follows the descriptor's link word to the next descriptor. It continues until it reaches a descriptor that marks the end of the chain.

Each memory port uses a plain request/acknowledge handshake. The channel raises `req` together with the address, the write enable and the write data, and holds all of them until `ack` arrives. On a read, `rdata` is taken in the cycle that `ack` is high. The channel reports that it is finished through a done flag. It can drive a level interrupt, which software clears with a strobe. An abort strobe stops a running transfer at once.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset the control register reads 0x10, meaning done=1 and enable=0. `irq` is low and neither port requests.
- R2: Register indexes are: 0 control, 1 mode, 2 host address, 3 local address, 4 byte count, 5 link word. In the control register, bit 0 is enable (read/write), bit 4 is done (read-only), and bits 1, 2 and 3 are the start, abort and clear-interrupt strobes, which always read as 0. The byte count register keeps only its low 23 bits.
- R3: A start strobe has effect only when the enable bit in the same write is 1 and done is 1. An accepted start clears done, so the control register reads 0x01 while the channel is busy.
- R4: The channel moves one word for every 4 bytes of the count, using count bits 22:2. Link bit 3 selects the direction: clear means host to local, set means local to host. The host address advances by 4 after each word. The local address also advances by 4, unless mode bit 11 is set, in which case it stays constant.
- R5: When mode bit 9 is set, a start fetches a descriptor from address {link[31:4],4'b0}. Link bit 0 selects the space it is read from: 1 means host space, 0 means local space. The four words at offsets 0, 4, 8 and 12 load, in that order, the host address, the local address, the byte count and the new link word.
- R6: After a descriptor whose link bit 1 is clear, the channel fetches the next descriptor through that link word. After a descriptor whose link bit 1 is set, or after a direct transfer, done becomes 1 and all requests stop.
- R7: A descriptor whose count bits 22:2 are zero completes without any data beat.
- R8: In chained mode with mode bit 16 set, every finished descriptor has 0 written to its count word, at offset 8, in the space the descriptor was fetched from.
- R9: `irq` is set after any descriptor whose link bit 2 is set. It is also set at the end of the chain when mode bit 10 is set. It stays high until a write to the control register with bit 3 set.
- R10: An abort strobe written while the channel is busy sets done and drops all requests in the next cycle. While the channel is idle, an abort has no effect.
- R11: At most one port requests at a time. A request keeps its address steady until `ack` arrives.
- R12: While the channel is busy, writes to registers 1 to 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hst_req | output | 1 | Host port request |
| hst_we | output | 1 | Host port write enable |
| hst_addr | output | 32 | Host port byte address |
| hst_wdata | output | 32 | Host port write data |
| hst_ack | input | 1 | Host port acknowledge |
| hst_rdata | input | 32 | Host port read data |
| lcl_req | output | 1 | Local port request |
| lcl_we | output | 1 | Local port write enable |
| lcl_addr | output | 32 | Local port byte address |
| lcl_wdata | output | 32 | Local port write data |
| lcl_ack | input | 1 | Local port acknowledge |
| lcl_rdata | input | 32 | Local port read data |
| irq | output | 1 | Channel interrupt (level) |

## Verification
The hardest situations to reach are the ones in the middle of a run: an abort while a request is still waiting for its acknowledge, and a register write that arrives while the channel is busy. The bench reaches both by starting a 64-word transfer that takes hundreds of cycles. A few cycles after the start it writes the mode register and then aborts. It then checks that the mode value did not change, that done is set in the very next cycle, and that the last destination word was never written. Chained runs are built from descriptors placed in both spaces, including one with a zero count, so that fetching across spaces and writing the count back are both exercised.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned CNT_W    = 23;
    localparam int unsigned RIDX_W   = 3;

    localparam logic [RIDX_W-1:0] RI_CTRL  = 3'd0;
    localparam logic [RIDX_W-1:0] RI_MODE  = 3'd1;
    localparam logic [RIDX_W-1:0] RI_HADDR = 3'd2;
    localparam logic [RIDX_W-1:0] RI_LADDR = 3'd3;
    localparam logic [RIDX_W-1:0] RI_COUNT = 3'd4;
    localparam logic [RIDX_W-1:0] RI_LINK  = 3'd5;

    // control byte bit positions
    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_GO   = 1;
    localparam int unsigned CB_ABT  = 2;
    localparam int unsigned CB_CLR  = 3;
    localparam int unsigned CB_DONE = 4;

    // mode register bit positions
    localparam int unsigned MB_CHAIN  = 9;
    localparam int unsigned MB_ENDIRQ = 10;
    localparam int unsigned MB_LFIX   = 11;
    localparam int unsigned MB_ZEROWB = 16;

    // link word bit positions
    localparam int unsigned LB_INHOST = 0;
    localparam int unsigned LB_LAST   = 1;
    localparam int unsigned LB_CNTIRQ = 2;
    localparam int unsigned LB_L2H    = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_SRC, ST_DST, ST_WBACK, ST_DESC_END
    } dmac_state_e;

    typedef enum logic [1:0] {
        PS_NONE, PS_HOST, PS_LOCAL
    } dmac_port_e;

    typedef struct packed {
        dmac_state_e       st;
        logic [1:0]        idx;
        logic              en;
        logic              done;
        logic              irq;
        logic [DATA_W-1:0] mode;
        logic [ADDR_W-1:0] haddr;
        logic [ADDR_W-1:0] laddr;
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] link;
        logic [ADDR_W-1:0] base;
        logic              base_host;
        logic [DATA_W-1:0] buf_w;
    } dmac_regs_t;
endpackage

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output dmac_regs_t        r_q
);
    localparam logic [AW-1:0] STEP     = AW'(DATA_W / 8);
    localparam logic [CW-1:0] CSTEP    = CW'(DATA_W / 8);
    localparam int unsigned   ALIGN_LO = 4;

    dmac_regs_t r_d;

    logic ctrl_wr;
    logic is_idle;
    logic go_ok;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = reg_we && (reg_addr == RI_CTRL);
        is_idle = (r_q.st == ST_IDLE);
        go_ok   = ctrl_wr && reg_wdata[CB_GO] && reg_wdata[CB_EN] && r_q.done;

        if (ctrl_wr) begin
            r_d.en = reg_wdata[CB_EN];
            if (reg_wdata[CB_CLR]) r_d.irq = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (go_ok) begin
                    r_d.done = 1'b0;
                    if (r_q.mode[MB_CHAIN]) begin
                        r_d.base      = {r_q.link[AW-1:ALIGN_LO], {ALIGN_LO{1'b0}}};
                        r_d.base_host = r_q.link[LB_INHOST];
                        r_d.idx       = 2'd0;
                        r_d.st        = ST_FETCH;
                    end else begin
                        r_d.st = ST_CHECK;
                    end
                end else if (reg_we) begin
                    unique case (reg_addr)
                        RI_MODE:  r_d.mode  = reg_wdata;
                        RI_HADDR: r_d.haddr = reg_wdata;
                        RI_LADDR: r_d.laddr = reg_wdata;
                        RI_COUNT: r_d.count = reg_wdata[CW-1:0];
                        RI_LINK:  r_d.link  = reg_wdata;
                        default:  ;
                    endcase
                end
            end
            ST_FETCH: begin
                if (bus_ack) begin
                    unique case (r_q.idx)
                        2'd0:    r_d.haddr = bus_rdata;
                        2'd1:    r_d.laddr = bus_rdata;
                        2'd2:    r_d.count = bus_rdata[CW-1:0];
                        default: r_d.link  = bus_rdata;
                    endcase
                    r_d.idx = r_q.idx + 2'd1;
                    if (r_q.idx == 2'd3) r_d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (r_q.count[CW-1:2] != '0) begin
                    r_d.st = ST_SRC;
                end else if (r_q.mode[MB_CHAIN] && r_q.mode[MB_ZEROWB]) begin
                    r_d.st = ST_WBACK;
                end else begin
                    r_d.st = ST_DESC_END;
                end
            end
            ST_SRC: begin
                if (bus_ack) begin
                    r_d.buf_w = bus_rdata;
                    r_d.st    = ST_DST;
                end
            end
            ST_DST: begin
                if (bus_ack) begin
                    r_d.haddr = r_q.haddr + STEP;
                    if (!r_q.mode[MB_LFIX]) r_d.laddr = r_q.laddr + STEP;
                    r_d.count = r_q.count - CSTEP;
                    r_d.st    = ST_CHECK;
                end
            end
            ST_WBACK: begin
                if (bus_ack) r_d.st = ST_DESC_END;
            end
            ST_DESC_END: begin
                if (r_q.link[LB_CNTIRQ]) r_d.irq = 1'b1;
                if (!r_q.mode[MB_CHAIN] || r_q.link[LB_LAST]) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.mode[MB_ENDIRQ]) r_d.irq = 1'b1;
                end else begin
                    r_d.base      = {r_q.link[AW-1:ALIGN_LO], {ALIGN_LO{1'b0}}};
                    r_d.base_host = r_q.link[LB_INHOST];
                    r_d.idx       = 2'd0;
                    r_d.st        = ST_FETCH;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (ctrl_wr && reg_wdata[CB_ABT] && !is_idle) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.done <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dmac_bus_drive.sv
module dmac_bus_drive
    import dmac_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  dmac_state_e   st,
    input  logic [1:0]    idx,
    input  logic [AW-1:0] base,
    input  logic          base_host,
    input  logic          to_host,
    input  logic [AW-1:0] haddr,
    input  logic [AW-1:0] laddr,
    input  logic [DW-1:0] buf_w,
    output logic          hst_req,
    output logic          hst_we,
    output logic [AW-1:0] hst_addr,
    output logic [DW-1:0] hst_wdata,
    input  logic          hst_ack,
    input  logic [DW-1:0] hst_rdata,
    output logic          lcl_req,
    output logic          lcl_we,
    output logic [AW-1:0] lcl_addr,
    output logic [DW-1:0] lcl_wdata,
    input  logic          lcl_ack,
    input  logic [DW-1:0] lcl_rdata,
    output logic          bus_ack,
    output logic [DW-1:0] bus_rdata
);
    localparam int unsigned  WB     = DW / 8;
    localparam logic [AW-1:0] CNT_OFS = AW'(2 * WB);

    dmac_port_e    sel;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    always_comb begin
        sel   = PS_NONE;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (st)
            ST_FETCH: begin
                sel  = base_host ? PS_HOST : PS_LOCAL;
                addr = base + AW'(idx) * AW'(WB);
            end
            ST_SRC: begin
                sel  = to_host ? PS_LOCAL : PS_HOST;
                addr = to_host ? laddr : haddr;
            end
            ST_DST: begin
                sel   = to_host ? PS_HOST : PS_LOCAL;
                addr  = to_host ? haddr : laddr;
                we    = 1'b1;
                wdata = buf_w;
            end
            ST_WBACK: begin
                sel  = base_host ? PS_HOST : PS_LOCAL;
                addr = base + CNT_OFS;
                we   = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        hst_req   = (sel == PS_HOST);
        hst_we    = hst_req && we;
        hst_addr  = hst_req ? addr : '0;
        hst_wdata = hst_req ? wdata : '0;
        lcl_req   = (sel == PS_LOCAL);
        lcl_we    = lcl_req && we;
        lcl_addr  = lcl_req ? addr : '0;
        lcl_wdata = lcl_req ? wdata : '0;
        bus_ack   = (hst_req && hst_ack) || (lcl_req && lcl_ack);
        bus_rdata = hst_req ? hst_rdata : lcl_rdata;
    end
endmodule

// File: rtl/dmac_reg_read.sv
module dmac_reg_read
    import dmac_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic [RIDX_W-1:0] addr,
    input  logic              en,
    input  logic              done,
    input  logic [DW-1:0]     mode,
    input  logic [DW-1:0]     haddr,
    input  logic [DW-1:0]     laddr,
    input  logic [CW-1:0]     count,
    input  logic [DW-1:0]     link,
    output logic [DW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            RI_CTRL: begin
                rdata[CB_EN]   = en;
                rdata[CB_DONE] = done;
            end
            RI_MODE:  rdata = mode;
            RI_HADDR: rdata = haddr;
            RI_LADDR: rdata = laddr;
            RI_COUNT: rdata = DW'(count);
            RI_LINK:  rdata = link;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              hst_req,
    output logic              hst_we,
    output logic [AW-1:0]     hst_addr,
    output logic [DW-1:0]     hst_wdata,
    input  logic              hst_ack,
    input  logic [DW-1:0]     hst_rdata,
    output logic              lcl_req,
    output logic              lcl_we,
    output logic [AW-1:0]     lcl_addr,
    output logic [DW-1:0]     lcl_wdata,
    input  logic              lcl_ack,
    input  logic [DW-1:0]     lcl_rdata,
    output logic              irq
);
    dmac_regs_t    r_q;
    logic          bus_ack;
    logic [DW-1:0] bus_rdata;

    dmac_engine #(.CW(CW), .AW(AW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .r_q       (r_q)
    );

    dmac_bus_drive #(.AW(AW), .DW(DW)) u_bus (
        .st        (r_q.st),
        .idx       (r_q.idx),
        .base      (r_q.base),
        .base_host (r_q.base_host),
        .to_host   (r_q.link[LB_L2H]),
        .haddr     (r_q.haddr),
        .laddr     (r_q.laddr),
        .buf_w     (r_q.buf_w),
        .hst_req   (hst_req),
        .hst_we    (hst_we),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_ack   (hst_ack),
        .hst_rdata (hst_rdata),
        .lcl_req   (lcl_req),
        .lcl_we    (lcl_we),
        .lcl_addr  (lcl_addr),
        .lcl_wdata (lcl_wdata),
        .lcl_ack   (lcl_ack),
        .lcl_rdata (lcl_rdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    dmac_reg_read #(.CW(CW), .DW(DW)) u_rd (
        .addr  (reg_addr),
        .en    (r_q.en),
        .done  (r_q.done),
        .mode  (r_q.mode),
        .haddr (r_q.haddr),
        .laddr (r_q.laddr),
        .count (r_q.count),
        .link  (r_q.link),
        .rdata (reg_rdata)
    );

    assign irq = r_q.irq;
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort_wr,
    input logic          clear_wr,
    input logic          start_off_wr,
    input logic          hst_req,
    input logic [AW-1:0] hst_addr,
    input logic          hst_ack,
    input logic          lcl_req,
    input logic [AW-1:0] lcl_addr,
    input logic          lcl_ack,
    input logic          irq,
    input logic          done_i
);
    assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hst_req, lcl_req}));

    assert_hold_host_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req && !hst_ack && !abort_wr |=> hst_req && $stable(hst_addr));

    assert_hold_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_req && !lcl_ack && !abort_wr |=> lcl_req && $stable(lcl_addr));

    assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr && !done_i |=> done_i && !hst_req && !lcl_req);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clear_wr |=> irq);

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> !hst_req && !lcl_req);

    assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_off_wr && done_i |=> done_i);
endmodule

bind dma_chain_ctrl dmac_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_wr     (reg_we && reg_addr == 3'd0 && reg_wdata[2]),
    .clear_wr     (reg_we && reg_addr == 3'd0 && reg_wdata[3]),
    .start_off_wr (reg_we && reg_addr == 3'd0 && reg_wdata[1] && !reg_wdata[0]),
    .hst_req      (hst_req),
    .hst_addr     (hst_addr),
    .hst_ack      (hst_ack),
    .lcl_req      (lcl_req),
    .lcl_addr     (lcl_addr),
    .lcl_ack      (lcl_ack),
    .irq          (irq),
    .done_i       (r_q.done)
);

// File: tb/dma_chain_ctrl_bench.sv
module dma_chain_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hst_req, hst_we, lcl_req, lcl_we, irq;
    logic [31:0] hst_addr, hst_wdata, lcl_addr, lcl_wdata;
    logic        hst_ack = 1'b0, lcl_ack = 1'b0;
    logic [31:0] hst_rdata, lcl_rdata;

    logic [31:0] hmem [256];
    logic [31:0] lmem [256];
    logic        h_ld = 1'b0, l_ld = 1'b0;
    logic [7:0]  ld_idx = '0;
    logic [31:0] ld_val = '0;

    int checks = 0;
    int errors = 0;
    int both_req = 0;
    int unstable = 0;
    logic        p_hreq = 1'b0, p_lreq = 1'b0, p_hack = 1'b0, p_lack = 1'b0;
    logic [31:0] p_haddr = '0, p_laddr = '0;

    always #10 clk = ~clk;

    dma_chain_ctrl u_dma_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .lcl_req(lcl_req), .lcl_we(lcl_we), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
        .lcl_ack(lcl_ack), .lcl_rdata(lcl_rdata), .irq(irq)
    );

    assign hst_rdata = hmem[hst_addr[9:2]];
    assign lcl_rdata = lmem[lcl_addr[9:2]];

    always @(posedge clk) begin
        hst_ack <= hst_req && !hst_ack;
        lcl_ack <= lcl_req && !lcl_ack;
        if (hst_req && hst_we && hst_ack) hmem[hst_addr[9:2]] <= hst_wdata;
        else if (h_ld) hmem[ld_idx] <= ld_val;
        if (lcl_req && lcl_we && lcl_ack) lmem[lcl_addr[9:2]] <= lcl_wdata;
        else if (l_ld) lmem[ld_idx] <= ld_val;
        if (hst_req && lcl_req) both_req++;
        if (p_hreq && !p_hack && hst_req && hst_addr != p_haddr) unstable++;
        if (p_lreq && !p_lack && lcl_req && lcl_addr != p_laddr) unstable++;
        p_hreq <= hst_req; p_hack <= hst_ack; p_haddr <= hst_addr;
        p_lreq <= lcl_req; p_lack <= lcl_ack; p_laddr <= lcl_addr;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ld(input bit host, input logic [7:0] i, input logic [31:0] v);
        @(negedge clk);
        h_ld = host; l_ld = !host; ld_idx = i; ld_val = v;
        @(negedge clk);
        h_ld = 1'b0; l_ld = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int n = 0; n < 3000; n++) begin
            rd(3'd0, v);
            if (v[4]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v);
        chk("R1 ctrl after reset", v, 32'h10);
        chk("R1 irq after reset", {31'b0, irq}, 0);
        chk("R1 no request", {30'b0, hst_req, lcl_req}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd4, 32'hFF80_0004);
        rd(3'd4, v);
        chk("R2 count keeps 23 bits", v, 32'h4);
        wr(3'd1, 32'h0001_0A00);
        rd(3'd1, v);
        chk("R2 mode readback", v, 32'h0001_0A00);
        wr(3'd0, 32'h0000_000D);
        rd(3'd0, v);
        chk("R2 strobes read zero", v, 32'h11);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_start_gate();
        logic [31:0] v;
        ld(0, 8'd224, 32'hCAFE_0224);
        wr(3'd1, 32'h0); wr(3'd2, 32'h40); wr(3'd3, 32'h380);
        wr(3'd4, 32'd4); wr(3'd5, 32'h0);
        wr(3'd0, 32'h2);
        repeat (10) @(negedge clk);
        rd(3'd0, v);
        chk("R3 start without enable keeps done", v, 32'h10);
        chk("R3 start without enable moves nothing", lmem[224], 32'hCAFE_0224);
    endtask

    task automatic t_direct_h2l();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) ld(1, 8'(16 + i), 32'hA000_0000 + 32'(i));
        wr(3'd1, 32'h0); wr(3'd2, 32'h40); wr(3'd3, 32'h80);
        wr(3'd4, 32'd16); wr(3'd5, 32'h0);
        wr(3'd0, 32'h3);
        wait_done();
        for (int i = 0; i < 4; i++)
            chk("R4 host-to-local data", lmem[32 + i], 32'hA000_0000 + 32'(i));
        rd(3'd0, v);
        chk("R6 done after direct run", v, 32'h11);
        rd(3'd2, v);
        chk("R4 host address advanced", v, 32'h50);
        chk("R9 no irq without request", {31'b0, irq}, 0);
    endtask

    task automatic t_direct_l2h_fixed();
        logic [31:0] v;
        ld(0, 8'd40, 32'h5555_0001);
        ld(1, 8'd67, 32'hDEAD_0067);
        wr(3'd1, 32'h800); wr(3'd2, 32'h100); wr(3'd3, 32'hA0);
        wr(3'd4, 32'd12); wr(3'd5, 32'h8);
        wr(3'd0, 32'h3);
        wait_done();
        for (int i = 0; i < 3; i++)
            chk("R4 local-to-host fixed source", hmem[64 + i], 32'h5555_0001);
        chk("R4 count limits beats", hmem[67], 32'hDEAD_0067);
        rd(3'd3, v);
        chk("R4 local address held", v, 32'hA0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        ld(1, 8'd128, 32'h180); ld(1, 8'd129, 32'h300);
        ld(1, 8'd130, 32'd8);   ld(1, 8'd131, 32'h0C0);
        ld(0, 8'd48, 32'h1A0);  ld(0, 8'd49, 32'h320);
        ld(0, 8'd50, 32'd8);    ld(0, 8'd51, 32'hA);
        ld(1, 8'd96, 32'hB000_0000); ld(1, 8'd97, 32'hB000_0001);
        ld(0, 8'd200, 32'hC000_0000); ld(0, 8'd201, 32'hC000_0001);
        wr(3'd1, 32'h600); wr(3'd5, 32'h201);
        wr(3'd0, 32'h3);
        wait_done();
        chk("R5 first descriptor from host space", lmem[192], 32'hB000_0000);
        chk("R5 first descriptor second word", lmem[193], 32'hB000_0001);
        chk("R6 linked descriptor from local space", hmem[104], 32'hC000_0000);
        chk("R6 linked descriptor second word", hmem[105], 32'hC000_0001);
        rd(3'd5, v);
        chk("R5 link loaded from descriptor", v, 32'hA);
        chk("R9 irq at chain end", {31'b0, irq}, 1);
        repeat (3) @(negedge clk);
        chk("R9 irq held", {31'b0, irq}, 1);
        wr(3'd0, 32'h9);
        chk("R9 irq cleared by strobe", {31'b0, irq}, 0);
    endtask

    task automatic t_zero_and_wb();
        ld(0, 8'd56, 32'h1C0); ld(0, 8'd57, 32'h340);
        ld(0, 8'd58, 32'h0);   ld(0, 8'd59, 32'h0F0);
        ld(0, 8'd60, 32'h1C0); ld(0, 8'd61, 32'h360);
        ld(0, 8'd62, 32'd8);   ld(0, 8'd63, 32'h2);
        ld(1, 8'd112, 32'hD000_0000); ld(1, 8'd113, 32'hD000_0001);
        ld(0, 8'd208, 32'hFEED_0208);
        wr(3'd1, 32'h0001_0200); wr(3'd5, 32'h0E0);
        wr(3'd0, 32'h3);
        wait_done();
        chk("R7 zero count moves no data", lmem[208], 32'hFEED_0208);
        chk("R7 next descriptor still runs", lmem[216], 32'hD000_0000);
        chk("R7 next descriptor second word", lmem[217], 32'hD000_0001);
        chk("R8 count written back to zero", lmem[62], 32'h0);
        chk("R8 zero-count descriptor written back", lmem[58], 32'h0);
        chk("R9 no irq without enable bits", {31'b0, irq}, 0);
    endtask

    task automatic t_count_irq();
        wr(3'd1, 32'h0); wr(3'd2, 32'h40); wr(3'd3, 32'h3F0);
        wr(3'd4, 32'd4); wr(3'd5, 32'h4);
        wr(3'd0, 32'h3);
        wait_done();
        chk("R9 irq on count flag", {31'b0, irq}, 1);
        wr(3'd0, 32'h9);
        chk("R9 clear after count irq", {31'b0, irq}, 0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        ld(0, 8'd63, 32'hBEEF_0063);
        wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        wr(3'd4, 32'h100); wr(3'd5, 32'h0);
        wr(3'd0, 32'h3);
        rd(3'd0, v);
        chk("R3 start clears done", v, 32'h01);
        wr(3'd1, 32'h800);
        rd(3'd1, v);
        chk("R12 mode write ignored while busy", v, 32'h0);
        wr(3'd0, 32'h5);
        chk("R10 requests dropped after abort", {30'b0, hst_req, lcl_req}, 0);
        rd(3'd0, v);
        chk("R10 done set by abort", v, 32'h11);
        repeat (20) @(negedge clk);
        chk("R10 transfer stopped", lmem[63], 32'hBEEF_0063);
        wr(3'd0, 32'h5);
        rd(3'd0, v);
        chk("R10 abort while idle has no effect", v, 32'h11);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            hmem[i] = '0;
            lmem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_start_gate();
        t_direct_h2l();
        t_direct_l2h_fixed();
        t_chain();
        t_zero_and_wb();
        t_count_irq();
        t_abort();
        chk("R11 never two requests", 32'(both_req), 0);
        chk("R11 address steady until ack", 32'(unstable), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule